// File: doc/BRIEF.md
# Track-Road Pattern Matching Array

This block is a grid of pattern roads for track finding. Each road keeps one four-layer pattern: one content-addressable word per detector layer, plus a small control cell that counts how many of its layers have matched and raises a road flag when that count reaches a programmable threshold. The grid is addressed by row and column. The default is 8 rows by 4 columns. The full-size arrangement is 128 by 32.

In load mode, software-side logic writes the pattern words. A value write stores a whole 15-bit word for one layer of one road. A second, mask write marks any of the three ternary positions of that word as don't-care. In run mode, a stream of hit words arrives, each tagged with a layer number. On each valid hit, the selected layer word of every road compares itself with the hit in a single clock. A successful compare sets a sticky per-layer match latch, which holds until a rearm pulse clears every latch in the array.

The readout presents the flags of all columns in one selected row as a single registered word.

Top module: `track_road_array`

## Requirements
- R1: After reset, `road_flags` is 0, and every stored value, ternary mask and match latch is 0.
- R2: With `mode_load`=1 and `wr_en`=1, the addressed row, column and layer word is written on the clock edge. When `wr_mask`=0, all 15 bits of `wr_data` are stored as the value. When `wr_mask`=1, `wr_data[10:8]` is stored as the ternary mask and the value is kept.
- R3: The word layout is: bits 14:11 bank select, bits 10:8 ternary, bits 7:0 binary. A compare matches only if all bank and binary bits are equal and every ternary bit whose mask bit is 0 is equal. A mask bit of 1 makes that ternary position always match.
- R4: With `mode_load`=0 and `hit_valid`=1, `hit_data` is compared with the word of layer `hit_layer` in every road on that edge. A matching road sets its latch for that layer. No other layer latch changes.
- R5: A set match latch stays set through later non-matching hits and idle cycles until a rearm.
- R6: `rearm`=1 clears every match latch in the array on that edge. When a hit arrives in the same cycle, the rearm wins and the latch ends up clear.
- R7: A road's flag is 1 when the number of its set latches is at least `threshold`. A threshold of 0 acts as 1, and thresholds 5 to 7 never raise a flag.
- R8: `road_flags[c]` is the flag of road (`rd_row`, c). It is registered, so it reflects the latches, `rd_row` and `threshold` as they stood before the previous clock edge.
- R9: Hits are ignored in load mode, and writes are ignored in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | 1 = load mode, 0 = run mode |
| wr_en | input | 1 | Pattern write strobe |
| wr_mask | input | 1 | 0 = value write, 1 = ternary mask write |
| wr_row | input | $clog2(ROWS) | Write row address |
| wr_col | input | $clog2(COLS) | Write column address |
| wr_layer | input | 2 | Write layer |
| wr_data | input | 15 | Write data |
| hit_valid | input | 1 | Hit strobe |
| hit_layer | input | 2 | Layer the hit belongs to |
| hit_data | input | 15 | Hit word |
| rearm | input | 1 | Clear all match latches |
| threshold | input | 3 | Minimum matched-layer count |
| rd_row | input | $clog2(ROWS) | Readout row |
| road_flags | output | COLS | Registered flags of the selected row |

## Verification
A hit presented before clock edge E sets its latch at E, and the flag word changes at edge E+1. A change to `threshold` or `rd_row` before edge E shows up after edge E. A rearm at edge E produces a zero flag word after E+1.

The bench drives all inputs on falling edges. After the last stimulus it lets two full clock edges pass before it samples on a falling edge, so every check reads a settled two-register result.

The bench sweeps every road with a full match. For one road it also sweeps every threshold code against every matched-layer count from 0 to 4, with the expected flag computed from the count.

// File: rtl/road_pkg.sv
package road_pkg;
   localparam int BANK_W   = 4;
   localparam int TERN_W   = 3;
   localparam int BIN_W    = 8;
   localparam int WORD_W   = BANK_W + TERN_W + BIN_W;
   localparam int TERN_LSB = BIN_W;
   localparam int LAYERS   = 4;
   localparam int LAYER_W  = 2;
   localparam int THR_W    = 3;

   typedef logic [WORD_W-1:0]  cam_word_t;
   typedef logic [TERN_W-1:0]  tern_mask_t;
   typedef logic [LAYER_W-1:0] layer_t;
   typedef logic [THR_W-1:0]   thr_t;
endpackage

// File: rtl/road_cam_cell.sv
module road_cam_cell
   import road_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_val,
   input  logic      wr_msk,
   input  cam_word_t wr_data,
   input  logic      cmp_en,
   input  cam_word_t cmp_data,
   input  logic      clr,
   output logic      matched
);
   cam_word_t  value_q;
   tern_mask_t mask_q;
   cam_word_t  dont_care;
   logic       equal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value_q <= '0;
         mask_q  <= '0;
      end else begin
         if (wr_val) value_q <= wr_data;
         if (wr_msk) mask_q  <= wr_data[TERN_LSB +: TERN_W];
      end
   end

   always_comb begin
      dont_care = '0;
      dont_care[TERN_LSB +: TERN_W] = mask_q;
      equal = (((value_q ^ cmp_data) & ~dont_care) == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                matched <= 1'b0;
      else if (clr)              matched <= 1'b0;
      else if (cmp_en && equal)  matched <= 1'b1;
   end
endmodule

// File: rtl/road_cell.sv
module road_cell
   import road_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_sel,
   input  logic      wr_mask,
   input  layer_t    wr_layer,
   input  cam_word_t wr_data,
   input  logic      hit_en,
   input  layer_t    hit_layer,
   input  cam_word_t hit_data,
   input  logic      clr,
   input  thr_t      thr_eff,
   output logic      flag
);
   logic [LAYERS-1:0] layer_match;
   thr_t              count;

   for (genvar l = 0; l < LAYERS; l++) begin : g_layer
      logic this_wr;
      assign this_wr = wr_sel && (wr_layer == layer_t'(l));
      road_cam_cell u_cam (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_val   (this_wr && !wr_mask),
         .wr_msk   (this_wr && wr_mask),
         .wr_data  (wr_data),
         .cmp_en   (hit_en && (hit_layer == layer_t'(l))),
         .cmp_data (hit_data),
         .clr      (clr),
         .matched  (layer_match[l])
      );
   end

   always_comb begin
      count = '0;
      for (int l = 0; l < LAYERS; l++) count = count + thr_t'(layer_match[l]);
      flag = (count >= thr_eff);
   end
endmodule

// File: rtl/road_flag_readout.sv
module road_flag_readout #(
   parameter int ROWS = 8,
   parameter int COLS = 4,
   parameter int RW   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ROWS*COLS-1:0] flag_all,
   input  logic [RW-1:0]        rd_row,
   output logic [COLS-1:0]      road_flags
);
   logic [COLS-1:0] row_pick;

   always_comb begin
      row_pick = '0;
      for (int r = 0; r < ROWS; r++)
         if (rd_row == RW'(r)) row_pick = flag_all[r*COLS +: COLS];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) road_flags <= '0;
      else        road_flags <= row_pick;
   end
endmodule

// File: rtl/track_road_array.sv
module track_road_array
   import road_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 4,
   localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_load,
   input  logic                wr_en,
   input  logic                wr_mask,
   input  logic [RW-1:0]       wr_row,
   input  logic [CW-1:0]       wr_col,
   input  logic [LAYER_W-1:0]  wr_layer,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic                hit_valid,
   input  logic [LAYER_W-1:0]  hit_layer,
   input  logic [WORD_W-1:0]   hit_data,
   input  logic                rearm,
   input  logic [THR_W-1:0]    threshold,
   input  logic [RW-1:0]       rd_row,
   output logic [COLS-1:0]     road_flags
);
   if (ROWS < 1 || COLS < 1) begin : g_bad_size
      $error("track_road_array: ROWS and COLS must be at least 1");
   end
   if (ROWS * COLS > 4096) begin : g_bad_total
      $error("track_road_array: more than 4096 roads requested");
   end

   logic                 wr_ok;
   logic                 hit_ok;
   thr_t                 thr_eff;
   logic [ROWS*COLS-1:0] flag_all;

   assign wr_ok   = mode_load && wr_en;
   assign hit_ok  = !mode_load && hit_valid;
   assign thr_eff = (threshold == '0) ? thr_t'(1) : threshold;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         logic sel;
         assign sel = wr_ok && (wr_row == RW'(r)) && (wr_col == CW'(c));
         road_cell u_road (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (sel),
            .wr_mask   (wr_mask),
            .wr_layer  (wr_layer),
            .wr_data   (wr_data),
            .hit_en    (hit_ok),
            .hit_layer (hit_layer),
            .hit_data  (hit_data),
            .clr       (rearm),
            .thr_eff   (thr_eff),
            .flag      (flag_all[r*COLS + c])
         );
      end
   end

   road_flag_readout #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_readout (
      .clk        (clk),
      .rst_n      (rst_n),
      .flag_all   (flag_all),
      .rd_row     (rd_row),
      .road_flags (road_flags)
   );
endmodule

// File: rtl/road_array_chk.sv
module road_array_chk #(
   parameter int ROWS = 8,
   parameter int COLS = 4,
   parameter int RW   = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mode_load,
   input logic            hit_valid,
   input logic            rearm,
   input logic [2:0]      threshold,
   input logic [RW-1:0]   rd_row,
   input logic [COLS-1:0] road_flags
);
   logic seen;
   always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // R6: rearm leaves an all-zero flag word two edges later
   a_r6_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      rearm |=> ##1 (road_flags == '0));

   // R7: thresholds above four never raise a flag
   a_r7_over_range: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (threshold > 3'd4) |=> (road_flags == '0));

   // R5: without a rearm, set flags do not fall
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (!$past(rearm) && $stable(rd_row) && $stable(threshold))
      |=> ((road_flags & $past(road_flags)) == $past(road_flags)));

   // R9: with no effective hit and no rearm, the flags hold
   a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (!$past(rearm) && !$past(hit_valid && !mode_load)
       && $stable(rd_row) && $stable(threshold))
      |=> $stable(road_flags));
endmodule

bind track_road_array road_array_chk #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_load  (mode_load),
   .hit_valid  (hit_valid),
   .rearm      (rearm),
   .threshold  (threshold),
   .rd_row     (rd_row),
   .road_flags (road_flags)
);

// File: tb/tb_track_road_array.sv
module tb_track_road_array;
   localparam int ROWS = 8;
   localparam int COLS = 4;
   localparam int RW   = 3;
   localparam int CW   = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            mode_load = 1'b1;
   logic            wr_en = 1'b0;
   logic            wr_mask = 1'b0;
   logic [RW-1:0]   wr_row = '0;
   logic [CW-1:0]   wr_col = '0;
   logic [1:0]      wr_layer = '0;
   logic [14:0]     wr_data = '0;
   logic            hit_valid = 1'b0;
   logic [1:0]      hit_layer = '0;
   logic [14:0]     hit_data = '0;
   logic            rearm = 1'b0;
   logic [2:0]      threshold = 3'd4;
   logic [RW-1:0]   rd_row = '0;
   logic [COLS-1:0] road_flags;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   track_road_array #(.ROWS(ROWS), .COLS(COLS)) dut (.*);

   function automatic logic [14:0] pat(int r, int c, int l);
      return {4'(r ^ 5), 3'((c + l) % 8), 8'((l << 5) | (r << 2) | c)};
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic settle();
      step(); step();
   endtask

   task automatic chk(string req, logic [COLS-1:0] exp);
      checks++;
      if (road_flags !== exp) begin
         failures++;
         $display("FAIL %s: road_flags=%b expected=%b", req, road_flags, exp);
      end
   endtask

   task automatic wr(int r, int c, int l, bit m, logic [14:0] d);
      wr_en = 1'b1; wr_mask = m; wr_row = RW'(r); wr_col = CW'(c);
      wr_layer = 2'(l); wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic hit(int l, logic [14:0] d);
      hit_valid = 1'b1; hit_layer = 2'(l); hit_data = d;
      step();
      hit_valid = 1'b0;
   endtask

   task automatic do_rearm();
      rearm = 1'b1; step(); rearm = 1'b0;
   endtask

   initial begin
      #900000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      settle(); settle();
      chk("R1 reset", '0);
      rst_n = 1'b1;
      settle();
      // R1: all values zero, so a zero hit in run mode matches every road
      mode_load = 1'b0; threshold = 3'd1;
      hit(0, 15'd0); settle();
      chk("R1 zero contents", '1);
      do_rearm(); settle();

      // R2: load every road with unique words
      mode_load = 1'b1;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            for (int l = 0; l < 4; l++) wr(r, c, l, 1'b0, pat(r, c, l));
      mode_load = 1'b0;

      // R2/R4/R8: full match on each road in turn
      threshold = 3'd4;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) begin
            do_rearm();
            rd_row = RW'(r);
            for (int l = 0; l < 4; l++) hit(l, pat(r, c, l));
            settle();
            chk("R2 R4 R8 road sweep", COLS'(1 << c));
         end

      // R7: threshold sweep on road (3,2)
      rd_row = 3'd3;
      for (int k = 0; k <= 4; k++) begin
         do_rearm();
         for (int l = 0; l < k; l++) hit(l, pat(3, 2, l));
         for (int t = 0; t < 8; t++) begin
            bit e;
            threshold = 3'(t);
            settle();
            e = (t == 0) ? (k >= 1) : ((t <= 4) ? (k >= t) : 1'b0);
            chk("R7 threshold", e ? 4'b0100 : 4'b0000);
         end
      end

      // R5: sticky across gaps and non-matching hits
      threshold = 3'd4; rd_row = 3'd1;
      do_rearm();
      hit(0, pat(1, 1, 0)); step();
      hit(0, pat(1, 1, 0) ^ 15'h0080); step(); step();
      hit(1, pat(1, 1, 1)); hit(2, pat(1, 1, 2)); step();
      hit(3, pat(1, 1, 3)); settle();
      chk("R5 sticky", 4'b0010);

      // R8: row select
      rd_row = 3'd5; settle();
      chk("R8 other row", 4'b0000);
      rd_row = 3'd1; settle();
      chk("R8 back to row", 4'b0010);

      // R6: rearm clears, and wins over a same-cycle hit
      do_rearm(); settle();
      chk("R6 rearm clears", 4'b0000);
      threshold = 3'd1; rd_row = 3'd0;
      rearm = 1'b1; hit_valid = 1'b1; hit_layer = 2'd0; hit_data = pat(0, 0, 0);
      step();
      rearm = 1'b0; hit_valid = 1'b0;
      settle();
      chk("R6 rearm priority", 4'b0000);

      // R3: ternary masking on road (0,0) layer 0
      mode_load = 1'b1;
      wr(0, 0, 0, 1'b1, 15'(3'b010 << 8));
      mode_load = 1'b0;
      do_rearm();
      hit(0, pat(0, 0, 0) ^ 15'h0200); settle();
      chk("R3 masked ternary bit", 4'b0001);
      do_rearm();
      hit(0, pat(0, 0, 0) ^ 15'h0100); settle();
      chk("R3 unmasked ternary bit", 4'b0000);
      do_rearm();
      hit(0, pat(0, 0, 0) ^ 15'h1000); settle();
      chk("R3 bank mismatch", 4'b0000);
      do_rearm();
      hit(0, pat(0, 0, 0) ^ 15'h0080); settle();
      chk("R3 binary mismatch", 4'b0000);
      do_rearm();
      hit(0, pat(0, 0, 0)); settle();
      chk("R3 mask write keeps value", 4'b0001);

      // R4: a hit on another layer sets nothing for this layer's data
      do_rearm();
      hit(1, pat(0, 0, 0)); settle();
      chk("R4 layer tag", 4'b0000);

      // R9: hits ignored in load mode
      do_rearm();
      mode_load = 1'b1;
      hit(0, pat(0, 0, 0)); settle();
      chk("R9 load-mode hit ignored", 4'b0000);
      mode_load = 1'b0;

      // R9: writes ignored in run mode
      wr(0, 1, 0, 1'b0, 15'h7ABC);
      do_rearm();
      hit(0, 15'h7ABC); settle();
      chk("R9 run-mode write ignored (new data)", 4'b0000);
      do_rearm();
      hit(0, pat(0, 1, 0)); settle();
      chk("R9 run-mode write ignored (old data)", 4'b0010);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule